// File: doc/BRIEF.md
# Message-Signaled Interrupt Generator

This block sits on the device side of a link and turns up to 32 internal interrupt sources into memory-write interrupt messages. Software sets it up through a small write-only register port. It programs a global enable, a destination address, a base data value, a per-vector mask and the number of vectors in use. Each source is a single-cycle event line. An event on a vector in use sets that vector's pending bit. While the function is enabled and the vector is unmasked, the block then forms one write request. The request carries the programmed address and a data word equal to the base plus the vector index.

Requests leave on a valid/ready port that carries address and data, with at most one request outstanding. When several vectors are pending, the lowest-numbered eligible vector goes first. The data word is the base plus the index, wrapping modulo 2^32, for any vector count from 1 to 32. The base needs no alignment, and the index is never substituted into low bits.

Top module: `irq_msg_gen`

## Requirements
- R1: After reset, `msg_valid` is low, and the enable, address, base, mask and count registers are all zero. With count zero, no event produces a message.
- R2: A write with `cfg_we` high updates the register chosen by `cfg_sel`: 0 = enable (bit 0), 1 = address, 2 = base data, 3 = mask, 4 = vector count (bits 5:0; values above 32 behave as 32). Writes to selects 5 to 7 change nothing.
- R3: While enable is 0, no new message is formed. Events that arrive while disabled are dropped. Writing enable to 0 clears every pending bit.
- R4: Every message carries the address register value on `msg_addr`.
- R5: The message for vector k carries `msg_data` = base + k modulo 2^32. With count 1, the only vector is 0 and its data equals the base.
- R6: An event on vector k with k >= count is ignored: it sets no pending bit and produces no message.
- R7: An event on a vector whose mask bit is 1 sets its pending bit but sends nothing. Clearing that mask bit later produces the message.
- R8: Among pending unmasked vectors, the lowest index is sent first. The others follow in increasing index order.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold. Only one message is outstanding at a time.
- R10: A vector's pending bit clears in the cycle its message is accepted (`msg_valid` and `msg_ready` both high). A new event on the same vector in that cycle leaves it pending, so a second message follows.
- R11: Register writes made while a message is presented do not change that message. They apply to the next message formed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| src_evt | input | 32 | Per-vector interrupt event pulses |
| msg_valid | output | 1 | Write request valid |
| msg_ready | input | 1 | Write request accepted by the transport |
| msg_addr | output | 32 | Write request address |
| msg_data | output | 32 | Write request data |

## Verification
The hardest case to reach from the ports is the accept cycle in which the same vector fires again. The pending clear and the new set land on one edge, and only the set may win. The bench holds `msg_ready` low until the message is presented. It then raises `msg_ready` and the event line for that vector on the same falling edge, and expects exactly one further message. A pending bit that disabling should wipe is also hidden behind a mask first, so that the only evidence is the absence of a message once the mask is lifted.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

    localparam int unsigned NUM_VEC = 32;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned VEC_W   = $clog2(NUM_VEC);
    localparam int unsigned CNT_W   = $clog2(NUM_VEC + 1);
    localparam int unsigned SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_ENABLE = 3'd0,
        SEL_ADDR   = 3'd1,
        SEL_BASE   = 3'd2,
        SEL_MASK   = 3'd3,
        SEL_COUNT  = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic               enable;
        logic [WORD_W-1:0]  addr;
        logic [WORD_W-1:0]  base;
        logic [NUM_VEC-1:0] mask;
        logic [CNT_W-1:0]   count;
    } cfg_t;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic [VEC_W-1:0]  vec;
    } msg_t;

    // Vectors below the programmed count are in use; counts above NUM_VEC saturate.
    function automatic logic [NUM_VEC-1:0] in_use(input logic [CNT_W-1:0] cnt);
        logic [NUM_VEC-1:0] m;
        for (int k = 0; k < NUM_VEC; k++) begin
            m[k] = (k < int'(cnt));
        end
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] vec_data(input logic [WORD_W-1:0] base,
                                                   input logic [VEC_W-1:0]  idx);
        return base + WORD_W'(idx);
    endfunction

endpackage

// File: rtl/irq_msg_cfg.sv
module irq_msg_cfg
    import irq_msg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] wdata,
    output cfg_t              cfg
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_ENABLE: cfg_q.enable <= wdata[0];
                SEL_ADDR:   cfg_q.addr   <= wdata;
                SEL_BASE:   cfg_q.base   <= wdata;
                SEL_MASK:   cfg_q.mask   <= wdata[NUM_VEC-1:0];
                SEL_COUNT:  cfg_q.count  <= wdata[CNT_W-1:0];
                default:    cfg_q        <= cfg_q;
            endcase
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/irq_msg_pend.sv
module irq_msg_pend
    import irq_msg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [NUM_VEC-1:0] use_vec,
    input  logic [NUM_VEC-1:0] evt,
    input  logic               clr_vld,
    input  logic [VEC_W-1:0]   clr_idx,
    output logic [NUM_VEC-1:0] pend
);

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (!enable || !use_vec[g]) begin
                bit_q <= 1'b0;
            end else if (evt[g]) begin
                bit_q <= 1'b1;              // a fresh event outranks the accept clear
            end else if (clr_vld && clr_idx == VEC_W'(g)) begin
                bit_q <= 1'b0;
            end
        end
        assign pend[g] = bit_q;
    end

endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb #(
    parameter int unsigned N = 32,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         gnt_vld,
    output logic [W-1:0] gnt_idx
);

    always_comb begin
        gnt_vld = |req;
        gnt_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) gnt_idx = W'(k);
        end
    end

endmodule

// File: rtl/irq_msg_out.sv
module irq_msg_out
    import irq_msg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [VEC_W-1:0]  idx,
    input  logic [WORD_W-1:0] addr,
    input  logic [WORD_W-1:0] base,
    input  logic              ready,
    output logic              valid,
    output msg_t              msg
);

    logic valid_q;
    msg_t msg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            msg_q   <= '0;
        end else if (valid_q) begin
            if (ready) valid_q <= 1'b0;
        end else if (load) begin
            valid_q    <= 1'b1;
            msg_q.addr <= addr;
            msg_q.data <= vec_data(base, idx);
            msg_q.vec  <= idx;
        end
    end

    assign valid = valid_q;
    assign msg   = msg_q;

endmodule

// File: rtl/irq_msg_gen.sv
module irq_msg_gen
    import irq_msg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [WORD_W-1:0]  cfg_wdata,
    input  logic [NUM_VEC-1:0] src_evt,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [WORD_W-1:0]  msg_addr,
    output logic [WORD_W-1:0]  msg_data
);

    cfg_t               cfg;
    msg_t               msg;
    logic               en_q;
    logic [WORD_W-1:0]  base_q;
    logic [NUM_VEC-1:0] use_vec;
    logic [NUM_VEC-1:0] pend;
    logic [NUM_VEC-1:0] eligible;
    logic               gnt_vld;
    logic [VEC_W-1:0]   gnt_idx;
    logic               accept;

    irq_msg_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    assign en_q    = cfg.enable;
    assign base_q  = cfg.base;
    assign use_vec = in_use(cfg.count);
    assign accept  = msg_valid && msg_ready;

    irq_msg_pend u_pend (
        .clk     (clk),
        .rst     (rst),
        .enable  (en_q),
        .use_vec (use_vec),
        .evt     (src_evt),
        .clr_vld (accept),
        .clr_idx (msg.vec),
        .pend    (pend)
    );

    assign eligible = pend & ~cfg.mask;

    irq_msg_arb #(.N(NUM_VEC)) u_arb (
        .req     (eligible),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    irq_msg_out u_out (
        .clk   (clk),
        .rst   (rst),
        .load  (en_q && gnt_vld),
        .idx   (gnt_idx),
        .addr  (cfg.addr),
        .base  (cfg.base),
        .ready (msg_ready),
        .valid (msg_valid),
        .msg   (msg)
    );

    assign msg_addr = msg.addr;
    assign msg_data = msg.data;

endmodule

// File: rtl/irq_msg_gen_chk.sv
module irq_msg_gen_chk
    import irq_msg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [WORD_W-1:0]  msg_addr,
    input logic [WORD_W-1:0]  msg_data,
    input logic               en,
    input logic [WORD_W-1:0]  base,
    input logic [NUM_VEC-1:0] use_vec,
    input logic [NUM_VEC-1:0] pend,
    input logic [VEC_W-1:0]   vec,
    input logic [NUM_VEC-1:0] src_evt
);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    assert_no_new_msg_R3: assert property (@(posedge clk) disable iff (rst)
        (!en && !msg_valid) |=> !msg_valid);

    assert_disable_clears_R3: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pend == '0));

    assert_out_of_range_R6: assert property (@(posedge clk) disable iff (rst)
        (pend & ~$past(use_vec)) == '0);

    assert_data_span_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> (WORD_W'(msg_data - $past(base)) < WORD_W'(NUM_VEC)));

    assert_accept_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready && !src_evt[vec]) |=> !pend[$past(vec)]);

endmodule

bind irq_msg_gen irq_msg_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .en        (en_q),
    .base      (base_q),
    .use_vec   (use_vec),
    .pend      (pend),
    .vec       (msg.vec),
    .src_evt   (src_evt)
);

// File: tb/irq_msg_gen_tb.sv
`timescale 1ns/1ps
module irq_msg_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] src_evt = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [31:0] msg_addr;
    logic [31:0] msg_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_msg_gen u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .src_evt   (src_evt),
        .msg_valid (msg_valid),
        .msg_ready (msg_ready),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fire(input logic [31:0] v);
        @(negedge clk);
        src_evt = v;
        @(negedge clk);
        src_evt = '0;
    endtask

    task automatic expect_msg(input logic [31:0] ea, input logic [31:0] ed, input string req);
        int w = 0;
        while (!msg_valid && w < 20) begin
            @(negedge clk);
            w++;
        end
        check(msg_valid, req, {31'd0, msg_valid}, 32'd1);
        if (msg_valid) begin
            check(msg_addr == ea, req, msg_addr, ea);
            check(msg_data == ed, req, msg_data, ed);
            msg_ready = 1'b1;
            @(negedge clk);
            msg_ready = 1'b0;
        end
    endtask

    task automatic expect_quiet(input int n, input string req);
        logic seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(!seen, req, {31'd0, seen}, 32'd0);
    endtask

    task automatic t_reset;
        check(msg_valid == 1'b0, "R1 valid low", {31'd0, msg_valid}, 32'd0);
        wr(3'd0, 32'd1);
        fire(32'h1);
        expect_quiet(8, "R1 count resets to zero");
        wr(3'd4, 32'd1);
        fire(32'h1);
        expect_msg(32'h0, 32'h0, "R1 address and base reset to zero");
    endtask

    task automatic t_basic;
        wr(3'd1, 32'hFEE0_1000);
        wr(3'd2, 32'h0000_0100);
        wr(3'd4, 32'd4);
        fire(32'h4);
        expect_msg(32'hFEE0_1000, 32'h0000_0102, "R4 R5 vector 2");
        fire(32'h8);
        expect_msg(32'hFEE0_1000, 32'h0000_0103, "R5 last vector of four");
    endtask

    task automatic t_single;
        wr(3'd2, 32'h1234_5677);
        wr(3'd4, 32'd1);
        fire(32'h1);
        expect_msg(32'hFEE0_1000, 32'h1234_5677, "R5 single vector gives base");
        fire(32'h2);
        expect_quiet(8, "R6 vector beyond count ignored");
        wr(3'd4, 32'd2);
        expect_quiet(4, "R6 ignored event left nothing pending");
    endtask

    task automatic t_wrap;
        wr(3'd2, 32'hFFFF_FFFE);
        wr(3'd4, 32'd8);
        fire(32'h8);
        expect_msg(32'hFEE0_1000, 32'h0000_0001, "R5 wrap modulo 2^32");
    endtask

    task automatic t_range;
        wr(3'd2, 32'h0000_0040);
        wr(3'd4, 32'd40);
        fire(32'h8000_0000);
        expect_msg(32'hFEE0_1000, 32'h0000_005F, "R2 count above 32 saturates");
        wr(3'd7, 32'hDEAD_BEEF);
        wr(3'd5, 32'hDEAD_BEEF);
        fire(32'h1);
        expect_msg(32'hFEE0_1000, 32'h0000_0040, "R2 unused selects ignored");
    endtask

    task automatic t_mask;
        wr(3'd3, 32'h0000_0020);
        fire(32'h20);
        expect_quiet(10, "R7 masked vector silent");
        wr(3'd3, 32'h0);
        expect_msg(32'hFEE0_1000, 32'h0000_0045, "R7 unmask releases pending");
    endtask

    task automatic t_prio;
        fire(32'h0000_0248);
        expect_msg(32'hFEE0_1000, 32'h0000_0043, "R8 lowest first");
        expect_msg(32'hFEE0_1000, 32'h0000_0046, "R8 second");
        expect_msg(32'hFEE0_1000, 32'h0000_0049, "R8 third");
        expect_quiet(6, "R8 no extra messages");
    endtask

    task automatic t_hold;
        logic [31:0] a0, d0;
        logic        ok = 1'b1;
        wr(3'd2, 32'h0000_0200);
        fire(32'h2);
        @(negedge clk);
        a0 = msg_addr; d0 = msg_data;
        check(msg_valid && d0 == 32'h201, "R9 presented", d0, 32'h201);
        cfg_we = 1'b1; cfg_sel = 3'd2; cfg_wdata = 32'h0000_0300;
        @(negedge clk);
        cfg_we = 1'b0;
        for (int i = 0; i < 5; i++) begin
            if (!msg_valid || msg_addr != a0 || msg_data != d0) ok = 1'b0;
            @(negedge clk);
        end
        check(ok, "R9 R11 stable while stalled", msg_data, d0);
        expect_msg(32'hFEE0_1000, 32'h0000_0201, "R11 presented message unchanged");
        fire(32'h2);
        expect_msg(32'hFEE0_1000, 32'h0000_0301, "R11 new base on next message");
    endtask

    task automatic t_disable;
        wr(3'd3, 32'h0000_0010);
        fire(32'h10);
        wr(3'd0, 32'd0);
        wr(3'd0, 32'd1);
        wr(3'd3, 32'h0);
        expect_quiet(10, "R3 disable clears pending");
        wr(3'd0, 32'd0);
        fire(32'h1);
        expect_quiet(6, "R3 no message while disabled");
        wr(3'd0, 32'd1);
        expect_quiet(6, "R3 event while disabled dropped");
    endtask

    task automatic t_rearm;
        int w = 0;
        fire(32'h2);
        while (!msg_valid && w < 20) begin
            @(negedge clk);
            w++;
        end
        check(msg_data == 32'h301, "R10 first message", msg_data, 32'h301);
        msg_ready = 1'b1;
        src_evt = 32'h2;
        @(negedge clk);
        msg_ready = 1'b0;
        src_evt = '0;
        expect_msg(32'hFEE0_1000, 32'h0000_0301, "R10 re-armed in accept cycle");
        expect_quiet(8, "R10 pending cleared after accept");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_basic;
        t_single;
        t_wrap;
        t_range;
        t_mask;
        t_prio;
        t_hold;
        t_disable;
        t_rearm;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule